// File: doc/BRIEF.md
# Flash Program/Erase Write-Sequence Guard

This block sits between a register bus and the high-voltage control of an on-chip flash array. Software reaches it through one write port that selects a control register, the address/data programming latches or a test register. The block accepts a program or erase pulse only after a fixed order of bus writes: arm the latches, load them with an address inside the flash window, then request the pulse in a later control write. While the pulse is active, the erase/program choice and the latched address and data are frozen.

The pulse reaches the array only while the external program-voltage-present input is high and no stop/wait request is pending. A stop/wait request ends the pulse at once. After the request is released, a ready output stays low for a recovery interval. The interval is longer when the delay-select bit is set, which software must do on fast bus clocks. Any write that the guard refuses produces a one-cycle `refused` pulse.

Top module: `flash_pe_guard`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge):
  - `seq_state` is 0 (idle).
  - `fire_q`, `arm_q`, `erase_mode`, `dly_q`, `pe_drive` and `refused` are 0.
  - `latch_addr`, `latch_data` and `test_bits` are 0.
  - `ready` is 1.
- R2: A write with `wr_sel`=1 loads `latch_addr`/`latch_data` from `wr_addr`/`wr_data` only while armed and not pulsing. Any other such write leaves both latches unchanged and is refused.
- R3: A latch write whose address lies outside [`WIN_LO`, `WIN_HI`] is refused. It leaves the latches unchanged and the sequencer state unchanged (armed stays armed, state 1).
- R4: Control register (`wr_sel`=0) bit fields:
  - bit0 is pulse-enable.
  - bit1 is latch-enable (arm).
  - bit2 selects erase.
  - bit3 selects delay.

  Pulse-enable is set only when the state is latch-written (2) and the same write keeps bit1=1. The state then becomes 3. A single write from idle that sets bit0 and bit1 together arms the latches (state 1), leaves pulse-enable clear and is refused.
- R5: Setting bit0 while armed with no valid latch write (state 1) is refused and leaves pulse-enable clear.
- R6: While pulsing (state 3):
  - A control write that changes bit1 or bit2 leaves arm and erase unchanged and is refused.
  - Latch writes are refused.
  - A control write with bit0=0 clears pulse-enable and returns the state to 2.
- R7: A control write with bit1=0 outside the pulse returns the state to 0 and discards the valid-latch status. After re-arming, a pulse request is refused until a new valid latch write arrives.
- R8: `pe_drive` is high only while pulse-enable is set, `vpp_ok` is high and `halt_req` is low. `halt_req` drops `pe_drive` in the same cycle and clears pulse-enable (state 2) at the next edge. A pulse request made while `halt_req` is high is refused.
- R9: Test register writes (`wr_sel`=2, low `TW` bits) take effect only while `test_mode` is high. Otherwise the write is refused. `test_bits` is cleared at the first edge with `test_mode` low.
- R10: `ready` is low while `halt_req` is high. After `halt_req` falls, `ready` stays low for `WAKE_LONG` clock edges if the delay bit is set, or `WAKE_SHORT` edges if it is clear.
- R11: `refused` is high for exactly the one cycle after the edge that took a refused write. It is low after every accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_sel | input | 2 | Target: 0 control, 1 latches, 2 test, 3 none |
| wr_addr | input | AW | Programming address for latch writes |
| wr_data | input | DW | Write data |
| vpp_ok | input | 1 | Program voltage present |
| halt_req | input | 1 | Stop/wait request |
| test_mode | input | 1 | Special test mode |
| pe_drive | output | 1 | High-voltage pulse enable to the array |
| erase_mode | output | 1 | 1 erase, 0 program |
| arm_q | output | 1 | Latch-enable bit |
| fire_q | output | 1 | Pulse-enable bit |
| dly_q | output | 1 | Delay-select bit |
| seq_state | output | 2 | 0 idle, 1 armed, 2 latch written, 3 pulsing |
| latch_addr | output | AW | Latched programming address |
| latch_data | output | DW | Latched programming data |
| test_bits | output | TW | Test register |
| ready | output | 1 | Array usable after stop recovery |
| refused | output | 1 | One-cycle pulse after a refused write |

## Verification
The bench aims at the ordering traps:
- Arm and fire requested in one write. A design that decodes both bits together would start the pulse with stale latches.
- A fire request straight after arming. A design that skipped the latch-write step would start the pulse with no valid latch.
- An out-of-window latch write. A guard that ignored the window would program a bad address.

During the pulse, the bench tries to flip the erase bit, drop the arm bit and overwrite the latches. A leaky guard shows a changed `erase_mode` or `latch_addr`. The bench also raises the stop request mid-pulse and times `ready` after release with the delay bit both clear and set. An off-by-one or ignored delay bit shows up as `ready` rising at the wrong edge.

// File: rtl/fpg_pkg.sv
// Shared encodings for the flash program/erase guard.
// Assumes a 4-bit control field in the low bits of the write data.
package fpg_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE    = 2'd0,
        SQ_ARMED   = 2'd1,
        SQ_WRITTEN = 2'd2,
        SQ_PULSE   = 2'd3
    } seq_state_e;

    localparam int CB_FIRE  = 0;
    localparam int CB_ARM   = 1;
    localparam int CB_ERASE = 2;
    localparam int CB_DLY   = 3;
    localparam int CTRL_W   = 4;

    localparam logic [1:0] SEL_CTRL  = 2'd0;
    localparam logic [1:0] SEL_LATCH = 2'd1;
    localparam logic [1:0] SEL_TEST  = 2'd2;
endpackage

// File: rtl/fpg_sequencer.sv
// Write-order sequencer: owns the state, erase and delay bits and decides
// which control and latch writes are accepted.
// Assumes at most one of ctrl_wr / latch_wr is high in a cycle.
module fpg_sequencer
    import fpg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              latch_wr,
    input  logic              latch_in_win,
    input  logic              halt_req,
    output seq_state_e        state_o,
    output logic              erase_o,
    output logic              dly_o,
    output logic              latch_take,
    output logic              rej
);
    seq_state_e state_q, state_n;
    logic       erase_q, erase_n, dly_q, dly_n;
    logic       armed, firing, valid;

    assign armed  = (state_q != SQ_IDLE);
    assign firing = (state_q == SQ_PULSE);
    assign valid  = (state_q == SQ_WRITTEN) || firing;

    // Next-state decision for control writes, latch writes and stop requests.
    always_comb begin
        state_n    = state_q;
        erase_n    = erase_q;
        dly_n      = dly_q;
        latch_take = 1'b0;
        rej        = 1'b0;
        if (ctrl_wr) begin
            dly_n = ctrl_wdata[CB_DLY];
            if (firing) begin
                if ((ctrl_wdata[CB_ARM] != armed) || (ctrl_wdata[CB_ERASE] != erase_q))
                    rej = 1'b1;
                if (!ctrl_wdata[CB_FIRE])
                    state_n = SQ_WRITTEN;
            end else begin
                erase_n = ctrl_wdata[CB_ERASE];
                if (!ctrl_wdata[CB_ARM]) begin
                    state_n = SQ_IDLE;
                    rej     = ctrl_wdata[CB_FIRE];
                end else if (!armed) begin
                    state_n = SQ_ARMED;
                    rej     = ctrl_wdata[CB_FIRE];
                end else if (ctrl_wdata[CB_FIRE]) begin
                    if (valid && !halt_req)
                        state_n = SQ_PULSE;
                    else
                        rej = 1'b1;
                end
            end
        end
        if (latch_wr) begin
            if (armed && !firing && latch_in_win) begin
                latch_take = 1'b1;
                state_n    = SQ_WRITTEN;
            end else begin
                rej = 1'b1;
            end
        end
        if (halt_req && state_n == SQ_PULSE)
            state_n = SQ_WRITTEN;
    end

    // State and control bit registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            erase_q <= 1'b0;
            dly_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            erase_q <= erase_n;
            dly_q   <= dly_n;
        end
    end

    assign state_o = state_q;
    assign erase_o = erase_q;
    assign dly_o   = dly_q;

    // R4
    pulse_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SQ_WRITTEN && state_q != SQ_PULSE) |=> (state_q != SQ_PULSE));
    // R6
    erase_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_PULSE) |=> $stable(erase_q));
    // R8
    halt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |=> (state_q != SQ_PULSE));
    // R7
    disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !ctrl_wdata[CB_ARM] && state_q != SQ_PULSE) |=> (state_q == SQ_IDLE));
endmodule

// File: rtl/fpg_latch_bank.sv
// Programming address/data latches with the flash window compare.
// Assumes the sequencer alone decides when a write is stored (take).
module fpg_latch_bank #(
    parameter int              AW     = 16,
    parameter int              DW     = 16,
    parameter logic [AW-1:0]   WIN_LO = 16'h8000,
    parameter logic [AW-1:0]   WIN_HI = 16'hBFFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          take,
    output logic          in_win,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q
);
    // Window compare on the incoming address.
    always_comb in_win = (wr_addr >= WIN_LO) && (wr_addr <= WIN_HI);

    // Latch storage, written only on an accepted latch write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (take) begin
            addr_q <= wr_addr;
            data_q <= wr_data;
        end
    end
endmodule

// File: rtl/fpg_test_reg.sv
// Test register writable only in special test mode, cleared outside it.
// Assumes test_mode is synchronous to clk.
module fpg_test_reg #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          test_mode,
    input  logic          wr,
    input  logic [TW-1:0] wdata,
    output logic [TW-1:0] test_q,
    output logic          rej
);
    // A test write outside test mode is refused.
    always_comb rej = wr && !test_mode;

    // Register update, forced to zero whenever test mode is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !test_mode)
            test_q <= '0;
        else if (wr)
            test_q <= wdata;
    end

    // R9
    test_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |=> (test_q == '0));
endmodule

// File: rtl/fpg_wake_timer.sv
// Stop-recovery timer: holds ready low during a stop request and for a
// chosen number of cycles after it ends. Assumes WAKE_SHORT >= 1.
module fpg_wake_timer #(
    parameter int WAKE_SHORT = 1,
    parameter int WAKE_LONG  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_req,
    input  logic dly,
    output logic ready
);
    localparam int CW = $clog2(WAKE_LONG + 1);
    logic [CW-1:0] cnt_q;

    // Reload while halted, count down after release.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (halt_req)
            cnt_q <= dly ? CW'(WAKE_LONG) : CW'(WAKE_SHORT);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign ready = !halt_req && (cnt_q == '0);

    // R10
    wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(halt_req) |-> !ready);
endmodule

// File: rtl/flash_pe_guard.sv
// Top of the flash program/erase guard: decodes bus writes, ties the
// sequencer, latches, test register and wake timer together and gates the
// high-voltage enable. Assumes one write per cycle selected by wr_sel.
module flash_pe_guard
    import fpg_pkg::*;
#(
    parameter int            AW         = 16,
    parameter int            DW         = 16,
    parameter int            TW         = 4,
    parameter logic [AW-1:0] WIN_LO     = 16'h8000,
    parameter logic [AW-1:0] WIN_HI     = 16'hBFFF,
    parameter int            WAKE_SHORT = 1,
    parameter int            WAKE_LONG  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          vpp_ok,
    input  logic          halt_req,
    input  logic          test_mode,
    output logic          pe_drive,
    output logic          erase_mode,
    output logic          arm_q,
    output logic          fire_q,
    output logic          dly_q,
    output logic [1:0]    seq_state,
    output logic [AW-1:0] latch_addr,
    output logic [DW-1:0] latch_data,
    output logic [TW-1:0] test_bits,
    output logic          ready,
    output logic          refused
);
    logic       ctrl_wr, latch_wr, test_wr;
    logic       in_win, take, seq_rej, tst_rej;
    seq_state_e st;

    // Write target decode.
    always_comb begin
        ctrl_wr  = wr_en && (wr_sel == SEL_CTRL);
        latch_wr = wr_en && (wr_sel == SEL_LATCH);
        test_wr  = wr_en && (wr_sel == SEL_TEST);
    end

    fpg_sequencer u_seq (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
        .ctrl_wdata(wr_data[CTRL_W-1:0]), .latch_wr(latch_wr),
        .latch_in_win(in_win), .halt_req(halt_req), .state_o(st),
        .erase_o(erase_mode), .dly_o(dly_q), .latch_take(take), .rej(seq_rej)
    );

    fpg_latch_bank #(.AW(AW), .DW(DW), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_lat (
        .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .wr_data(wr_data),
        .take(take), .in_win(in_win), .addr_q(latch_addr), .data_q(latch_data)
    );

    fpg_test_reg #(.TW(TW)) u_tst (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .wr(test_wr),
        .wdata(wr_data[TW-1:0]), .test_q(test_bits), .rej(tst_rej)
    );

    fpg_wake_timer #(.WAKE_SHORT(WAKE_SHORT), .WAKE_LONG(WAKE_LONG)) u_wake (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .dly(dly_q), .ready(ready)
    );

    assign seq_state = st;
    assign arm_q     = (st != SQ_IDLE);
    assign fire_q    = (st == SQ_PULSE);
    assign pe_drive  = fire_q && vpp_ok && !halt_req;

    // One-cycle refusal strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) refused <= 1'b0;
        else        refused <= seq_rej || tst_rej;
    end

    // R6
    latch_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_PULSE) |=> ($stable(latch_addr) && $stable(latch_data)));
    // R11
    refused_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refused |-> $past(wr_en));
endmodule

// File: tb/sim_flash_pe_guard.sv
module sim_flash_pe_guard;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 0, rst_n = 0, wr_en = 0;
    logic [1:0]  wr_sel = 0;
    logic [15:0] wr_addr = 0, wr_data = 0;
    logic        vpp_ok = 0, halt_req = 0, test_mode = 0;
    logic        pe_drive, erase_mode, arm_q, fire_q, dly_q, ready, refused;
    logic [1:0]  seq_state;
    logic [15:0] latch_addr, latch_data;
    logic [3:0]  test_bits;
    int          n_chk = 0, n_bad = 0;
    bit          done = 0;

    flash_pe_guard u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One bus write; starts and ends at a falling edge.
    task automatic wr(input logic [1:0] sel, input logic [15:0] a, input logic [15:0] d);
        wr_en = 1; wr_sel = sel; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic t_reset;
        check("R1 state", seq_state, 0); check("R1 fire", fire_q, 0);
        check("R1 arm", arm_q, 0);       check("R1 erase", erase_mode, 0);
        check("R1 dly", dly_q, 0);       check("R1 drive", pe_drive, 0);
        check("R1 latch", {latch_addr, latch_data}, 0);
        check("R1 test", test_bits, 0);  check("R1 ready", ready, 1);
        check("R1 refused", refused, 0);
    endtask

    task automatic t_latch_unarmed;
        wr(1, 16'h8004, 16'h1234);
        check("R2 unarmed refused", refused, 1);
        check("R2 unarmed latch", latch_addr, 0);
        @(negedge clk);
        check("R11 strobe one cycle", refused, 0);
    endtask

    task automatic t_arm_fire_same;
        wr(0, 0, 16'h0003);
        check("R4 same-write refused", refused, 1);
        check("R4 same-write fire", fire_q, 0);
        check("R4 same-write state", seq_state, 1);
    endtask

    task automatic t_fire_no_latch;
        wr(0, 0, 16'h0003);
        check("R5 refused", refused, 1);
        check("R5 fire", fire_q, 0);
    endtask

    task automatic t_window;
        wr(1, 16'h1000, 16'h5555);
        check("R3 refused", refused, 1);
        check("R3 state", seq_state, 1);
        check("R3 latch", latch_addr, 0);
        wr(1, 16'hC000, 16'h5555);
        check("R3 above window", refused, 1);
    endtask

    task automatic t_good_fire;
        wr(1, 16'h8010, 16'hBEEF);
        check("R2 accepted", refused, 0);
        check("R2 state", seq_state, 2);
        check("R2 addr", latch_addr, 16'h8010);
        check("R2 data", latch_data, 16'hBEEF);
        wr(0, 0, 16'h0007);
        check("R4 fire", fire_q, 1);
        check("R4 state", seq_state, 3);
        check("R4 erase", erase_mode, 1);
        check("R8 no vpp", pe_drive, 0);
        vpp_ok = 1; #1;
        check("R8 drive", pe_drive, 1);
        @(negedge clk);
    endtask

    task automatic t_lock;
        wr(0, 0, 16'h0003);
        check("R6 erase change refused", refused, 1);
        check("R6 erase held", erase_mode, 1);
        wr(0, 0, 16'h0005);
        check("R6 disarm refused", refused, 1);
        check("R6 arm held", arm_q, 1);
        check("R6 still pulsing", seq_state, 3);
        wr(1, 16'h8020, 16'h0001);
        check("R6 latch refused", refused, 1);
        check("R6 latch held", latch_addr, 16'h8010);
        wr(0, 0, 16'h0006);
        check("R6 release state", seq_state, 2);
        check("R6 release refused", refused, 0);
        check("R6 drive off", pe_drive, 0);
    endtask

    task automatic t_halt;
        wr(0, 0, 16'h0003);
        check("R8 refire", seq_state, 3);
        halt_req = 1; #1;
        check("R8 immediate drop", pe_drive, 0);
        check("R10 ready low", ready, 0);
        @(negedge clk);
        check("R8 pulse cleared", seq_state, 2);
        wr(0, 0, 16'h0003);
        check("R8 fire under halt", refused, 1);
        check("R8 fire under halt state", seq_state, 2);
        halt_req = 0; #1;
        check("R10 short hold", ready, 0);
        @(negedge clk);
        check("R10 short release", ready, 1);
    endtask

    task automatic t_wake_long;
        wr(0, 0, 16'h000A);
        check("R10 dly set", dly_q, 1);
        halt_req = 1;
        @(negedge clk); @(negedge clk);
        halt_req = 0;
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk);
            check("R10 long window", ready, (i >= 4) ? 1 : 0);
        end
    endtask

    task automatic t_disarm;
        wr(0, 0, 16'h0000);
        check("R7 idle", seq_state, 0);
        wr(0, 0, 16'h0002);
        check("R7 rearmed", seq_state, 1);
        wr(0, 0, 16'h0003);
        check("R7 stale latch refused", refused, 1);
        check("R7 fire", fire_q, 0);
    endtask

    task automatic t_test;
        wr(2, 0, 16'h000F);
        check("R9 refused", refused, 1);
        check("R9 no write", test_bits, 0);
        test_mode = 1;
        wr(2, 0, 16'h000A);
        check("R9 write", test_bits, 4'hA);
        check("R9 accepted", refused, 0);
        test_mode = 0;
        @(negedge clk);
        check("R9 cleared", test_bits, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset;
        t_latch_unarmed;
        t_arm_fire_same;
        t_fire_no_latch;
        t_window;
        t_good_fire;
        t_lock;
        t_halt;
        t_wake_long;
        t_disarm;
        t_test;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule